// File: doc/BRIEF.md
# Branch Compare and Next-PC Select Unit

This purely combinational unit sits in the execute stage of a single-issue core. It compares two register operands and exports two flags: an equality flag and a less-than flag. One control input chooses how the less-than flag reads the operands, either as two's-complement signed values or as unsigned magnitudes. The equality flag is the same in both modes. The control decoder uses both flags to decide whether a branch is taken.

The same unit also forms the next program counter. A take input chooses between two values. When it is low, the result is the current PC plus one instruction (4 bytes), and this sum wraps modulo 2^32. When it is high, the result is the jump or branch target computed upstream by the ALU. Decoding the branch condition from the instruction is handled elsewhere.

Top module: `br_unit`

## Requirements
- R1: `eq_o` is 1 exactly when `a_i` equals `b_i`, bit for bit.
- R2: With `unsigned_i` = 0, `lt_o` is 1 exactly when `a_i` is less than `b_i` as 32-bit two's-complement numbers.
- R3: With `unsigned_i` = 1, `lt_o` is 1 exactly when `a_i` is less than `b_i` as unsigned 32-bit numbers.
- R4: When `a_i` equals `b_i`, `lt_o` is 0 in both modes.
- R5: `eq_o` does not depend on `unsigned_i`. Toggling it with fixed operands leaves `eq_o` unchanged.
- R6: With `take_i` = 0, `next_pc_o` equals `pc_i + 4` modulo 2^32. For example, 0xFFFFFFFC yields 0x00000000.
- R7: With `take_i` = 1, `next_pc_o` equals `target_i` unchanged.
- R8: Sign boundary. For `a_i` = 0x80000000 and `b_i` = 0x7FFFFFFF, `lt_o` is 1 in signed mode and 0 in unsigned mode. With the operands swapped, `lt_o` is 0 in signed mode and 1 in unsigned mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First compare operand (rs1 value) |
| b_i | input | 32 | Second compare operand (rs2 value) |
| unsigned_i | input | 1 | 1: unsigned compare, 0: signed compare |
| pc_i | input | 32 | Current program counter |
| target_i | input | 32 | Computed jump/branch target from the ALU |
| take_i | input | 1 | 1: select target, 0: select sequential PC |
| eq_o | output | 1 | Operands equal |
| lt_o | output | 1 | First operand less than second, per mode |
| next_pc_o | output | 32 | Selected next program counter |

## Verification
The comparison and the next-PC selection always evaluate together, from independent inputs. The bench therefore changes operands, mode, PC, target and take in the same step. It then checks the two flags against the operand values alone and checks `next_pc_o` against the PC/target rule alone. A crossed wire or shared term between the two paths therefore shows up as a wrong flag or a wrong PC. Sign-boundary operands are combined with the wrapping PC in these steps, so that both corner cases are present at the same time.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int unsigned XLEN_DEF  = 32;
  localparam int unsigned INSN_BYTES = 4;

  typedef enum logic {
    CMP_SIGNED   = 1'b0,
    CMP_UNSIGNED = 1'b1
  } cmp_mode_e;

  typedef enum logic {
    PC_SEQ    = 1'b0,
    PC_TARGET = 1'b1
  } pc_sel_e;
endpackage

// File: rtl/br_eq_unit.sv
module br_eq_unit #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            eq_o
);
  logic [XLEN-1:0] diff_bits;

  assign diff_bits = a_i ^ b_i;
  assign eq_o      = ~(|diff_bits);
endmodule

// File: rtl/br_lt_unit.sv
module br_lt_unit
  import br_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  cmp_mode_e       mode_i,
  output logic            lt_o
);
  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN:0] diff;
  logic          borrow;
  logic          sign_diff;

  // Borrow out of a zero-extended subtract gives the unsigned less-than
  assign diff      = {1'b0, a_i} - {1'b0, b_i};
  assign borrow    = diff[XLEN];
  assign sign_diff = a_i[MSB] ^ b_i[MSB];

  always_comb begin
    if (mode_i == CMP_UNSIGNED) begin
      lt_o = borrow;
    end else begin
      // Opposite signs: the negative operand is smaller
      lt_o = sign_diff ? a_i[MSB] : borrow;
    end
  end
endmodule

// File: rtl/br_next_pc.sv
module br_next_pc
  import br_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned STEP = INSN_BYTES
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] target_i,
  input  pc_sel_e         sel_i,
  output logic [XLEN-1:0] next_pc_o
);
  localparam logic [XLEN-1:0] STEP_W = XLEN'(STEP);

  logic [XLEN-1:0] seq_pc;

  assign seq_pc = pc_i + STEP_W;

  always_comb begin
    unique case (sel_i)
      PC_TARGET: next_pc_o = target_i;
      default:   next_pc_o = seq_pc;
    endcase
  end
endmodule

// File: rtl/br_unit.sv
module br_unit
  import br_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            unsigned_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] target_i,
  input  logic            take_i,
  output logic            eq_o,
  output logic            lt_o,
  output logic [XLEN-1:0] next_pc_o
);
  cmp_mode_e cmp_mode;
  pc_sel_e   pc_sel;

  assign cmp_mode = unsigned_i ? CMP_UNSIGNED : CMP_SIGNED;
  assign pc_sel   = take_i ? PC_TARGET : PC_SEQ;

  br_eq_unit #(.XLEN(XLEN)) i_eq (
    .a_i  (a_i),
    .b_i  (b_i),
    .eq_o (eq_o)
  );

  br_lt_unit #(.XLEN(XLEN)) i_lt (
    .a_i    (a_i),
    .b_i    (b_i),
    .mode_i (cmp_mode),
    .lt_o   (lt_o)
  );

  br_next_pc #(.XLEN(XLEN), .STEP(INSN_BYTES)) i_npc (
    .pc_i      (pc_i),
    .target_i  (target_i),
    .sel_i     (pc_sel),
    .next_pc_o (next_pc_o)
  );
endmodule

// File: rtl/br_unit_chk.sv
module br_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic            unsigned_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] target_i,
  input logic            take_i,
  input logic            eq_o,
  input logic            lt_o,
  input logic [XLEN-1:0] next_pc_o
);
  localparam logic [XLEN-1:0] STEP_W = XLEN'(4);

  always_comb begin
    AST_EQ_MATCH: assert (eq_o == (a_i == b_i)); // R1
    AST_LT_SIGNED: assert (unsigned_i || (lt_o == ($signed(a_i) < $signed(b_i)))); // R2
    AST_LT_UNSIGNED: assert (!unsigned_i || (lt_o == (a_i < b_i))); // R3
    AST_EQ_NOT_LT: assert (!eq_o || !lt_o); // R4
    AST_PC_SEQ: assert (take_i || (next_pc_o == pc_i + STEP_W)); // R6
    AST_PC_TARGET: assert (!take_i || (next_pc_o == target_i)); // R7
  end
endmodule

bind br_unit br_unit_chk #(.XLEN(XLEN)) i_br_unit_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .unsigned_i (unsigned_i),
  .pc_i       (pc_i),
  .target_i   (target_i),
  .take_i     (take_i),
  .eq_o       (eq_o),
  .lt_o       (lt_o),
  .next_pc_o  (next_pc_o)
);

// File: tb/test_br_unit.sv
module test_br_unit;
  logic        clk;
  logic        rst_ni;
  logic [31:0] a_i, b_i, pc_i, target_i;
  logic        unsigned_i, take_i;
  logic        eq_o, lt_o;
  logic [31:0] next_pc_o;

  int n_checks = 0;
  int n_fail   = 0;

  br_unit i_br_unit (
    .a_i(a_i), .b_i(b_i), .unsigned_i(unsigned_i),
    .pc_i(pc_i), .target_i(target_i), .take_i(take_i),
    .eq_o(eq_o), .lt_o(lt_o), .next_pc_o(next_pc_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic un,
                       input logic [31:0] pc, input logic [31:0] tg, input logic tk);
    @(negedge clk);
    a_i = a; b_i = b; unsigned_i = un; pc_i = pc; target_i = tg; take_i = tk;
    #2;
  endtask

  function automatic logic exp_lt(input logic [31:0] a, input logic [31:0] b, input logic un);
    if (un) return a < b;
    return $signed(a) < $signed(b);
  endfunction

  // Flags and next PC checked together on every step
  task automatic step(input string req, input logic [31:0] a, input logic [31:0] b,
                      input logic un, input logic [31:0] pc, input logic [31:0] tg,
                      input logic tk);
    drive(a, b, un, pc, tg, tk);
    chk({req, " R1 eq"}, {31'b0, eq_o}, {31'b0, a == b});
    chk({req, un ? " R3 lt" : " R2 lt"}, {31'b0, lt_o}, {31'b0, exp_lt(a, b, un)});
    chk({req, tk ? " R7 npc" : " R6 npc"}, next_pc_o, tk ? tg : pc + 32'd4);
  endtask

  task automatic t_reset_state;
    drive('0, '0, 1'b0, '0, '0, 1'b0);
    chk("idle R1", {31'b0, eq_o}, 32'd1);
    chk("idle R4", {31'b0, lt_o}, 32'd0);
    chk("idle R6", next_pc_o, 32'd4);
  endtask

  task automatic t_sign_boundary;
    drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 32'h100, 32'h200, 1'b0);
    chk("R8 signed min<max", {31'b0, lt_o}, 32'd1);
    drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 32'h100, 32'h200, 1'b0);
    chk("R8 unsigned min>max", {31'b0, lt_o}, 32'd0);
    drive(32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 32'h100, 32'h200, 1'b0);
    chk("R8 signed swap", {31'b0, lt_o}, 32'd0);
    drive(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 32'h100, 32'h200, 1'b0);
    chk("R8 unsigned swap", {31'b0, lt_o}, 32'd1);
  endtask

  task automatic t_equal_operands;
    logic [31:0] vals [4] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
    foreach (vals[i]) begin
      for (int m = 0; m < 2; m++) begin
        drive(vals[i], vals[i], m[0], 32'h40, 32'h80, 1'b1);
        chk("R4 eq no lt", {31'b0, lt_o}, 32'd0);
        chk("R1 eq set", {31'b0, eq_o}, 32'd1);
      end
    end
  endtask

  task automatic t_eq_mode_indep;
    logic e0;
    drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0, 32'h0, 1'b0);
    e0 = eq_o;
    drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R5 eq stable ne", {31'b0, eq_o}, {31'b0, e0});
    chk("R5 eq clear", {31'b0, eq_o}, 32'd0);
    drive(32'h5555_AAAA, 32'h5555_AAAA, 1'b1, 32'h0, 32'h0, 1'b0);
    e0 = eq_o;
    drive(32'h5555_AAAA, 32'h5555_AAAA, 1'b0, 32'h0, 32'h0, 1'b0);
    chk("R5 eq stable eq", {31'b0, eq_o}, {31'b0, e0});
  endtask

  task automatic t_pc_select;
    drive(32'h1, 32'h2, 1'b0, 32'hFFFF_FFFC, 32'hDEAD_BEE0, 1'b0);
    chk("R6 wrap", next_pc_o, 32'h0000_0000);
    drive(32'h1, 32'h2, 1'b0, 32'hFFFF_FFFE, 32'hDEAD_BEE0, 1'b0);
    chk("R6 wrap odd", next_pc_o, 32'h0000_0002);
    drive(32'h1, 32'h2, 1'b0, 32'hFFFF_FFFC, 32'hDEAD_BEE0, 1'b1);
    chk("R7 target", next_pc_o, 32'hDEAD_BEE0);
    drive(32'h1, 32'h2, 1'b0, 32'h0000_1000, 32'hFFFF_FFFF, 1'b1);
    chk("R7 target ones", next_pc_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_concurrent;
    step("mix", 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 32'hFFFF_FFFC, 32'h0000_0010, 1'b0);
    step("mix", 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 32'hFFFF_FFFC, 32'h0000_0010, 1'b1);
    step("mix", 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 32'h0000_0100, 32'h0000_0400, 1'b1);
    step("mix", 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0100, 32'h0000_0400, 1'b0);
    step("mix", 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 32'h7FFF_FFFC, 32'h8000_0000, 1'b0);
    step("mix", 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 32'h7FFF_FFFC, 32'h8000_0000, 1'b1);
    step("mix", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 32'h1234_5678, 1'b0);
    step("mix", 32'h0001_0000, 32'h0000_FFFF, 1'b1, 32'hABCD_EF00, 32'h1234_5678, 1'b1);
    step("mix", 32'h0000_0004, 32'h0000_0004, 1'b0, 32'h0000_0008, 32'h0000_0000, 1'b1);
  endtask

  initial begin
    rst_ni = 1'b0;
    a_i = '0; b_i = '0; unsigned_i = 1'b0; pc_i = '0; target_i = '0; take_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_sign_boundary();
    t_equal_operands();
    t_eq_mode_indep();
    t_pc_select();
    t_concurrent();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule